// File: doc/BRIEF.md
# Serial Gain Control Port

This block is a slave port on a three-wire serial link: a serial clock, an active-low frame strobe and a single data line that runs in both directions. A host uses it to write and read one 10-bit gain code. The block holds that code and presents it in parallel to the gain stage. The code is a plain value, and the block applies no gain law to it. The three serial pins are brought into the system clock domain through two-stage synchronisers, and each frame is decoded in that domain.

A frame opens when the strobe falls. The host then shifts in a direction bit (0 writes, 1 reads) and a four-bit register address. After these come the data bits, least significant bit first, with room for up to eleven positions. Write data is collected in a staging register. The gain code takes the new value only when the strobe rises again. In a read, the port drives the stored code back on the data line after the fifth serial-clock falling edge and moves to the next bit on each later falling edge. The data line has an output and an output-enable pin, and the enable is the only thing that tells the pad when to drive. Every pin is a plain level, so no valid/ready handshake applies here and the block never applies back-pressure.

Top module: `serial_gain_if`

## Requirements
- R1: While the active-low reset `rst_n` is low, and afterwards until the first valid write, `gain_o` holds the default code 0x096.
- R2: A write frame has the direction bit 0, then the address bits 1,0,0,0 in the order sent, then ten data bits sent D0 first. When such a frame carries at least 15 bits, `gain_o` takes the data on the third `clk` rising edge after `sl_i` rises.
- R3: While a write frame is being shifted, `gain_o` keeps its previous value up to the rise of `sl_i`.
- R4: A frame that holds fewer than 15 serial-clock rising edges when `sl_i` rises leaves `gain_o` unchanged.
- R5: A write frame whose four address bits are not 1,0,0,0 in the order sent leaves `gain_o` unchanged.
- R6: A sixteenth bit (the eleventh data position) is discarded, so the stored code comes only from data bits D0 to D9.
- R7: In a read frame (direction bit 1, matching address), `sdata_oe` is high and `sdata_o` carries gain bit k after the (5+k)-th falling edge of `sck_i`, for k = 0 to 9. A read leaves `gain_o` unchanged.
- R8: `sdata_oe` is low when `sl_i` is high, during the header of any frame, at every point of a write frame, and from the 15th falling edge of a read frame onwards.
- R9: A reset asserted in the middle of a frame returns `gain_o` to 0x096 and drops the partial frame.
- R10: Serial-clock edges that arrive while `sl_i` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| sck_i | input | 1 | Serial clock from the host |
| sl_i | input | 1 | Frame strobe. Low for the whole frame, rising edge commits |
| sdata_i | input | 1 | Serial data from the pad |
| sdata_o | output | 1 | Serial read data towards the pad |
| sdata_oe | output | 1 | Pad drive enable for `sdata_o` |
| gain_o | output | 10 | Committed gain code |

## Verification
Every serial pin passes through two synchroniser flops, and edge detection adds one more flop. The stored gain code therefore changes on the third `clk` edge after `sl_i` rises, and a read bit appears on `sdata_o` three edges after each `sck_i` fall. The bench drives serial-clock half periods of eight `clk` cycles. It samples `gain_o` six cycles after the strobe rises and samples the read data six cycles after each falling edge, which is past the due cycle and still before the next pin change. The "held" checks sample just before the strobe rises. In this way each result is seen only once it is due and before any later stimulus could change it.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  parameter int DATA_W      = 10;
  parameter int ADDR_W      = 4;
  parameter int HDR_W       = 1 + ADDR_W;
  parameter int SLOT_W      = DATA_W + 1;
  parameter int FRAME_BITS  = HDR_W + SLOT_W;
  parameter int MIN_BITS    = HDR_W + DATA_W;
  parameter int CNT_W       = $clog2(FRAME_BITS + 1);
  parameter logic [DATA_W-1:0] GAIN_DEFAULT = 10'h096;
  // address bit [0] is the first address bit on the wire
  parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'b0001;
endpackage

// File: rtl/sgi_sync.sv
module sgi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] st1_q, st2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q  <= INIT;
      st2_q  <= INIT;
      prev_q <= INIT;
    end else begin
      st1_q  <= pin_i;
      st2_q  <= st1_q;
      prev_q <= st2_q;
    end
  end

  assign lvl_o  = st2_q;
  assign rise_o = st2_q & ~prev_q;
  assign fall_o = ~st2_q & prev_q;
endmodule

// File: rtl/sgi_frame.sv
module sgi_frame
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sl_s,
  input  logic              sl_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sd_s,
  input  logic [DATA_W-1:0] gain_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              sdata_o,
  output logic              sdata_oe
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] MINB  = CNT_W'(MIN_BITS);
  localparam logic [CNT_W-1:0] RD_LO = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] RD_HI = CNT_W'(HDR_W + DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt_q, fall_cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] stage_q;
  logic              rd_hit, wr_hit, rd_phase, rd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      fall_cnt_q <= '0;
      hdr_q      <= '0;
      stage_q    <= '0;
    end else if (sl_s) begin
      bit_cnt_q  <= '0;
      fall_cnt_q <= '0;
    end else begin
      if (sck_rise && bit_cnt_q != LAST) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        for (int h = 0; h < HDR_W; h++)
          if (bit_cnt_q == CNT_W'(h)) hdr_q[h] <= sd_s;
        for (int k = 0; k < DATA_W; k++)
          if (bit_cnt_q == CNT_W'(HDR_W + k)) stage_q[k] <= sd_s;
      end
      if (sck_fall && fall_cnt_q != LAST)
        fall_cnt_q <= fall_cnt_q + 1'b1;
    end
  end

  assign wr_hit   = !hdr_q[0] && hdr_q[HDR_W-1:1] == GAIN_ADDR;
  assign rd_hit   =  hdr_q[0] && hdr_q[HDR_W-1:1] == GAIN_ADDR;
  assign rd_phase = fall_cnt_q >= RD_LO && fall_cnt_q <= RD_HI;

  always_comb begin
    rd_bit = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (fall_cnt_q == CNT_W'(HDR_W + k)) rd_bit = gain_i[k];
  end

  assign commit_o      = sl_rise && wr_hit && bit_cnt_q >= MINB;
  assign commit_data_o = stage_q;
  assign bit_cnt_o     = bit_cnt_q;
  assign sdata_oe      = !sl_s && rd_hit && rd_phase;
  assign sdata_o       = sdata_oe & rd_bit;
endmodule

// File: rtl/sgi_gain_reg.sv
module sgi_gain_reg
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] gain_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_o <= GAIN_DEFAULT;
    else if (load_i) gain_o <= data_i;
  end
endmodule

// File: rtl/serial_gain_if.sv
module serial_gain_if
  import sgi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sl_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic [DATA_W-1:0] gain_o
);
  // pin order in the synchroniser: {sdata, sl, sck}
  logic [2:0]        lvl, rise, fall;
  logic              commit;
  logic [DATA_W-1:0] commit_data;
  logic [CNT_W-1:0]  bit_cnt;

  sgi_sync #(.W(3), .INIT(3'b010)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({sdata_i, sl_i, sck_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  sgi_frame frame_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sl_s          (lvl[1]),
    .sl_rise       (rise[1]),
    .sck_rise      (rise[0]),
    .sck_fall      (fall[0]),
    .sd_s          (lvl[2]),
    .gain_i        (gain_o),
    .commit_o      (commit),
    .commit_data_o (commit_data),
    .bit_cnt_o     (bit_cnt),
    .sdata_o       (sdata_o),
    .sdata_oe      (sdata_oe)
  );

  sgi_gain_reg gain_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (commit),
    .data_i (commit_data),
    .gain_o (gain_o)
  );
endmodule

// File: rtl/serial_gain_if_chk.sv
module serial_gain_if_chk
  import sgi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sl_i,
  input logic              sl_s,
  input logic              sl_rise,
  input logic              sck_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sdata_o,
  input logic              sdata_oe,
  input logic [DATA_W-1:0] gain_o
);
  a_r3_commit_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_o) |-> $past(sl_rise));

  a_r4_short_frame_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_rise && bit_cnt < CNT_W'(MIN_BITS)) |=> $stable(gain_o));

  a_r8_drive_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !$past(sl_i, 2));

  a_r7_bit_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && !$past(sck_fall)) |-> $stable(sdata_o));

  a_r10_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_s && $past(sl_s)) |-> bit_cnt == '0);
endmodule

bind serial_gain_if serial_gain_if_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sl_i     (sl_i),
  .sl_s     (lvl[1]),
  .sl_rise  (rise[1]),
  .sck_fall (fall[0]),
  .bit_cnt  (bit_cnt),
  .sdata_o  (sdata_o),
  .sdata_oe (sdata_oe),
  .gain_o   (gain_o)
);

// File: tb/serial_gain_if_tb_top.sv
module serial_gain_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sl = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [9:0] gain;
  logic [9:0] exp_gain = 10'h096;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  serial_gain_if dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sl_i(sl), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe(sdo_oe), .gain_o(gain)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic rnw, input logic [3:0] a, input logic [9:0] d,
                                     input logic extra);
    return {extra, d, a, rnw};  // bit0 first on the wire
  endfunction

  // nb = number of bits shifted; rd = check readback against exp_gain
  task automatic frame(input logic [15:0] b, input int nb, input logic rd, input string req);
    logic oe_bad = 1'b0;
    sl = 1'b0;
    for (int i = 0; i < nb; i++) begin
      sdi = b[i];
      repeat (8) @(negedge clk);
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
      repeat (6) @(negedge clk);
      if (rd && i + 1 >= 5 && i + 1 <= 14) begin
        chk({req, " R7 oe"}, {9'd0, sdo_oe}, 10'd1);
        chk({req, " R7 bit"}, {9'd0, sdo}, {9'd0, exp_gain[i - 4]});
      end else if (sdo_oe) oe_bad = 1'b1;
    end
    repeat (4) @(negedge clk);
    chk({req, " R3 held"}, gain, exp_gain);
    chk({req, " R8 no drive"}, {9'd0, oe_bad}, 10'd0);
    sl = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", gain, 10'h096);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", gain, 10'h096);
    chk("R8 idle", {9'd0, sdo_oe}, 10'd0);

    // R2/R7 sweep: write then read back a spread of codes
    for (int v = 0; v < 1024; v += 13) begin
      logic [9:0] d = 10'(v ^ (v >> 3));
      frame(mk(1'b0, 4'b0001, d, 1'b0), 15, 1'b0, "R2 write");
      exp_gain = d;
      chk("R2 commit", gain, exp_gain);
      frame(mk(1'b1, 4'b0001, 10'd0, 1'b0), 16, 1'b1, "R7 read");
      chk("R7 read keeps gain", gain, exp_gain);
    end
    frame(mk(1'b0, 4'b0001, 10'h3ff, 1'b0), 15, 1'b0, "R2 ones");
    exp_gain = 10'h3ff;
    chk("R2 all ones", gain, exp_gain);

    // R6: 16-bit frame, extra bit 0 must not matter
    frame(mk(1'b0, 4'b0001, 10'h2a5, 1'b0), 16, 1'b0, "R6 extra");
    exp_gain = 10'h2a5;
    chk("R6 eleventh bit dropped", gain, exp_gain);

    // R4: short frames of every length below 15
    for (int n = 1; n < 15; n++) begin
      frame(mk(1'b0, 4'b0001, 10'h155, 1'b1), n, 1'b0, "R4 short");
      chk("R4 short frame no commit", gain, exp_gain);
    end

    // R5: every wrong address
    for (int a = 0; a < 16; a++) begin
      if (a != 1) begin
        frame(mk(1'b0, 4'(a), 10'h0f0, 1'b0), 15, 1'b0, "R5 addr");
        chk("R5 wrong address ignored", gain, exp_gain);
      end
    end

    // R8: read of a wrong address never drives
    frame(mk(1'b1, 4'b0010, 10'd0, 1'b0), 16, 1'b0, "R8 bad read");

    // R10: serial clocks with the strobe high
    for (int i = 0; i < 16; i++) begin
      sdi = 1'(i % 2);
      repeat (8) @(negedge clk); sck = 1'b1;
      repeat (8) @(negedge clk); sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R10 idle clocks ignored", gain, exp_gain);
    chk("R10 no drive", {9'd0, sdo_oe}, 10'd0);
    frame(mk(1'b0, 4'b0001, 10'h0c3, 1'b0), 15, 1'b0, "R10 next");
    exp_gain = 10'h0c3;
    chk("R10 following frame aligned", gain, exp_gain);

    // R9: reset in the middle of a frame
    sl = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sdi = 1'b1;
      repeat (8) @(negedge clk); sck = 1'b1;
      repeat (8) @(negedge clk); sck = 1'b0;
    end
    rst_n = 1'b0;
    sl = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset mid frame", gain, 10'h096);
    rst_n = 1'b1;
    exp_gain = 10'h096;
    repeat (6) @(negedge clk);
    chk("R9 stays default", gain, exp_gain);
    frame(mk(1'b1, 4'b0001, 10'd0, 1'b0), 16, 1'b1, "R9 read");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule